// File: doc/BRIEF.md
# Processor Interrupt Pin Front-End

This block stands between six control pins that come from outside the processor and the core's exception logic. Every pin first crosses a two-flop synchronizer. A change detector then compares the synchronized value with a stored copy of the last level it accepted. A pin only has an effect when its level really changes, so a pin that stays at one level produces no new events.

Four of the pins feed pending bits. The external interrupt, the system management interrupt and the soft reset are active-high level sources, and each of their pending bits follows its pin. The machine check pin reacts to a falling edge: that edge sets a sticky pending bit, and the bit stays set until the core acknowledges it. The checkstop pin and the hard reset pin are active low. They drive a halt output and a core reset request directly. A registered hard-interrupt request is the OR of all pending bits.

The core clears a pending bit with a one-cycle acknowledge that carries a source index. An acknowledge can clear the edge-triggered machine check bit. It cannot clear a level source while that source's pin is still active.

Top module: `pin_irq_frontend`

## Requirements
- R1: While reset is asserted, and right after it, `pendingVec`, `hardIrqReq`, `haltCore` and `coreResetReq` are all 0.
- R2: A pin level that is driven before clock edge k shows up at the outputs after edge k+2 (two synchronizer stages plus one state register). It does not show up after edge k+1.
- R3: `pendingVec[0]` follows the external interrupt pin (active high), with the R2 latency.
- R4: `pendingVec[1]` follows the system management interrupt pin (active high), with the R2 latency.
- R5: A high-to-low change on `mcheckPinN` sets `pendingVec[2]`. A low-to-high change leaves the bit as it is. The bit stays set until it is acknowledged.
- R6: An acknowledge with `ackIdx` = 2 clears `pendingVec[2]` at the next edge. If a new falling edge is detected at that same edge, the bit stays set.
- R7: An acknowledge with `ackIdx` = 0, 1 or 3 does not clear the pending bit of that source while its pin is high.
- R8: `haltCore` is 1 while `ckstopPinN` is low and returns to 0 when the pin goes high again, with the R2 latency.
- R9: `coreResetReq` is 1 while `hresetPinN` is low, with the R2 latency.
- R10: `pendingVec[3]` follows the soft reset pin (active high), with the R2 latency.
- R11: `hardIrqReq` is 1 exactly when at least one bit of `pendingVec` is 1. It drops only when all four bits are 0.
- R12: If `mcheckPinN` is held low after its pending bit has been acknowledged, the bit is not set again. Only a fresh high-to-low change sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extIrqPin | input | 1 | External interrupt pin, active high level |
| smiPin | input | 1 | System management interrupt pin, active high level |
| mcheckPinN | input | 1 | Machine check pin, falling-edge sensitive |
| ckstopPinN | input | 1 | Checkstop pin, active low level |
| hresetPinN | input | 1 | Hard reset pin, active low level |
| sresetPin | input | 1 | Soft reset pin, active high level |
| ackValid | input | 1 | Acknowledge strobe, one cycle wide |
| ackIdx | input | 2 | Source to acknowledge: 0 ext, 1 smi, 2 machine check, 3 soft reset |
| pendingVec | output | 4 | Pending bits in source-index order |
| hardIrqReq | output | 1 | Combined interrupt request |
| haltCore | output | 1 | Halt request to the core |
| coreResetReq | output | 1 | Core reset request |

## Verification
The bench goes after the following cases.
- **Edge acknowledged in the same cycle as a new falling edge.** A design that gives the clear priority would lose a machine check.
- **Machine check pin held low after an acknowledge.** A detector that works on level instead of on change would raise the bit again over and over.
- **Acknowledge aimed at a level source whose pin is still active.** A design that clears the bit unconditionally would drop an interrupt that is still being requested.
- **Sample-by-sample latency, including one-cycle pulses.** These expose a synchronizer with a missing or extra stage, or a request that drops while another source is still pending.

// File: rtl/pinfe_pkg.sv
package pinfe_pkg;
  localparam int NUM_PINS  = 6;
  localparam int NUM_SRC   = 4;
  localparam int SRC_IDX_W = $clog2(NUM_SRC);

  // pin positions in the packed raw-pin vector
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CKSTOP = 3;
  localparam int PIN_HRESET = 4;
  localparam int PIN_SRESET = 5;

  // inactive level of each pin, used as reset value of all pin state
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 6'b011100;

  typedef enum logic [1:0] {SENS_HIGH, SENS_LOW, SENS_FALL} sens_e;

  // pending source -> pin and sensitivity
  localparam int    SRC_PIN  [NUM_SRC] = '{PIN_EXT, PIN_SMI, PIN_MCHK, PIN_SRESET};
  localparam sens_e SRC_SENS [NUM_SRC] = '{SENS_HIGH, SENS_HIGH, SENS_FALL, SENS_HIGH};

  typedef struct packed {
    logic [NUM_PINS-1:0] lastWe;
    logic [NUM_SRC-1:0]  pendSet;
    logic [NUM_SRC-1:0]  pendClr;
    logic                haltSet;
    logic                haltClr;
    logic                rstSet;
    logic                rstClr;
  } ctrl_strobe_t;
endpackage

// File: rtl/pinfe_datapath.sv
module pinfe_datapath
  import pinfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  ctrl_strobe_t        strobe,
  output logic [NUM_PINS-1:0] syncPin,
  output logic [NUM_PINS-1:0] lastLvl,
  output logic [NUM_SRC-1:0]  pending,
  output logic                irqReq,
  output logic                halt,
  output logic                coreRst
);
  logic [NUM_SRC-1:0] pendNext;

  // per-pin synchronizer chain, reset to the pin's idle level
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{PIN_IDLE[i]}};
      else       chain <= {chain[SYNC_STAGES-2:0], pinRaw[i]};
    end
    assign syncPin[i] = chain[SYNC_STAGES-1];

    // last accepted level, written only on a real change
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 lastLvl[i] <= PIN_IDLE[i];
      else if (strobe.lastWe[i]) lastLvl[i] <= syncPin[i];
    end
  end

  // set wins over clear
  assign pendNext = (pending & ~strobe.pendClr) | strobe.pendSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      irqReq  <= 1'b0;
    end else begin
      pending <= pendNext;
      irqReq  <= |pendNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halt    <= 1'b0;
      coreRst <= 1'b0;
    end else begin
      if (strobe.haltSet)      halt <= 1'b1;
      else if (strobe.haltClr) halt <= 1'b0;
      if (strobe.rstSet)       coreRst <= 1'b1;
      else if (strobe.rstClr)  coreRst <= 1'b0;
    end
  end
endmodule

// File: rtl/pinfe_control.sv
module pinfe_control
  import pinfe_pkg::*;
(
  input  logic [NUM_PINS-1:0]  syncPin,
  input  logic [NUM_PINS-1:0]  lastLvl,
  input  logic                 ackValid,
  input  logic [SRC_IDX_W-1:0] ackIdx,
  output ctrl_strobe_t         strobe
);
  logic [NUM_PINS-1:0] pinChg;
  logic [NUM_SRC-1:0]  ackHit;
  logic [NUM_SRC-1:0]  setVec;
  logic [NUM_SRC-1:0]  clrVec;

  assign pinChg = syncPin ^ lastLvl;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int P = SRC_PIN[s];
    assign ackHit[s] = ackValid && (ackIdx == SRC_IDX_W'(s));
    if (SRC_SENS[s] == SENS_FALL) begin : g_fall
      // sticky: set on high-to-low change, cleared only by acknowledge
      assign setVec[s] = pinChg[P] & ~syncPin[P];
      assign clrVec[s] = ackHit[s];
    end else begin : g_level
      // follows the pin; acknowledge is honoured only with the pin inactive
      assign setVec[s] = pinChg[P] & syncPin[P];
      assign clrVec[s] = (pinChg[P] & ~syncPin[P]) | (ackHit[s] & ~syncPin[P]);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.lastWe  = pinChg;
    strobe.pendSet = setVec;
    strobe.pendClr = clrVec;
    strobe.haltSet = pinChg[PIN_CKSTOP] & ~syncPin[PIN_CKSTOP];
    strobe.haltClr = pinChg[PIN_CKSTOP] &  syncPin[PIN_CKSTOP];
    strobe.rstSet  = pinChg[PIN_HRESET] & ~syncPin[PIN_HRESET];
    strobe.rstClr  = pinChg[PIN_HRESET] &  syncPin[PIN_HRESET];
  end
endmodule

// File: rtl/pin_irq_frontend.sv
module pin_irq_frontend
  import pinfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extIrqPin,
  input  logic                 smiPin,
  input  logic                 mcheckPinN,
  input  logic                 ckstopPinN,
  input  logic                 hresetPinN,
  input  logic                 sresetPin,
  input  logic                 ackValid,
  input  logic [1:0]           ackIdx,
  output logic [3:0]           pendingVec,
  output logic                 hardIrqReq,
  output logic                 haltCore,
  output logic                 coreResetReq
);
  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] syncPin;
  logic [NUM_PINS-1:0] lastLvl;
  ctrl_strobe_t        strobe;

  assign pinRaw = {sresetPin, hresetPinN, ckstopPinN, mcheckPinN, smiPin, extIrqPin};

  pinfe_control ctrl_i (
    .syncPin  (syncPin),
    .lastLvl  (lastLvl),
    .ackValid (ackValid),
    .ackIdx   (ackIdx),
    .strobe   (strobe)
  );

  pinfe_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinRaw  (pinRaw),
    .strobe  (strobe),
    .syncPin (syncPin),
    .lastLvl (lastLvl),
    .pending (pendingVec),
    .irqReq  (hardIrqReq),
    .halt    (haltCore),
    .coreRst (coreResetReq)
  );
endmodule

// File: rtl/pin_irq_frontend_chk.sv
module pin_irq_frontend_chk (
  input logic       clk,
  input logic       rstN,
  input logic       extIrqPin,
  input logic       smiPin,
  input logic       mcheckPinN,
  input logic       ckstopPinN,
  input logic       hresetPinN,
  input logic       sresetPin,
  input logic       ackValid,
  input logic [1:0] ackIdx,
  input logic [3:0] pendingVec,
  input logic       hardIrqReq,
  input logic       haltCore,
  input logic       coreResetReq
);
  AST_EXT_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    pendingVec[0] == $past(extIrqPin, 3)); // R3
  AST_SMI_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    pendingVec[1] == $past(smiPin, 3)); // R4
  AST_SRST_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    pendingVec[3] == $past(sresetPin, 3)); // R10
  AST_HALT_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    haltCore == !$past(ckstopPinN, 3)); // R8
  AST_RESET_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    coreResetReq == !$past(hresetPinN, 3)); // R9
  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    hardIrqReq == (|pendingVec)); // R11
  AST_MCHK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendingVec[2] && !(ackValid && ackIdx == 2'd2)) |=> pendingVec[2]); // R5
  AST_MCHK_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackIdx == 2'd2 && !($past(mcheckPinN, 3) && !$past(mcheckPinN, 2)))
      |=> !pendingVec[2]); // R6
endmodule

bind pin_irq_frontend pin_irq_frontend_chk chk_i (.*);

// File: tb/pin_irq_frontend_tb_top.sv
`timescale 1ns/1ps
module pin_irq_frontend_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extIrqPin = 1'b0, smiPin = 1'b0, mcheckPinN = 1'b1;
  logic ckstopPinN = 1'b1, hresetPinN = 1'b1, sresetPin = 1'b0;
  logic ackValid = 1'b0;
  logic [1:0] ackIdx = 2'd0;
  logic [3:0] pendingVec;
  logic hardIrqReq, haltCore, coreResetReq;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_irq_frontend dut_i (.*);

  // behavioural reference model
  logic [5:0] hist[$];
  logic [5:0] mLast;
  logic [3:0] mPend;
  logic mIrq, mHalt, mRst;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist.delete();
      mLast = 6'b011100; mPend = '0; mIrq = 0; mHalt = 0; mRst = 0;
    end else begin
      logic [5:0] v;
      logic [3:0] np;
      hist.push_back({sresetPin, hresetPinN, ckstopPinN, mcheckPinN, smiPin, extIrqPin});
      v = (hist.size() >= 3) ? hist[hist.size()-3] : 6'b011100;
      if (hist.size() > 4) void'(hist.pop_front());
      np = mPend;
      if (ackValid && ackIdx == 2'd2) np[2] = 1'b0;
      if (v[0] != mLast[0]) np[0] = v[0];
      if (v[1] != mLast[1]) np[1] = v[1];
      if (v[2] != mLast[2] && !v[2]) np[2] = 1'b1;
      if (v[5] != mLast[5]) np[3] = v[5];
      if (v[3] != mLast[3]) mHalt = !v[3];
      if (v[4] != mLast[4]) mRst = !v[4];
      mLast = v;
      mPend = np;
      mIrq = |np;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vecCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (!done) begin
    cmp("R3", "pend[0]", pendingVec[0], mPend[0]);
    cmp("R4", "pend[1]", pendingVec[1], mPend[1]);
    cmp("R5", "pend[2]", pendingVec[2], mPend[2]);
    cmp("R10", "pend[3]", pendingVec[3], mPend[3]);
    cmp("R11", "irq", hardIrqReq, mIrq);
    cmp("R8", "halt", haltCore, mHalt);
    cmp("R9", "reset", coreResetReq, mRst);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(logic [1:0] idx);
    ackValid = 1'b1; ackIdx = idx;
    step(1);
    ackValid = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  endtask

  initial begin
    #100000;
    failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(3);
    cmp("R1", "reset pend", pendingVec, 0);
    cmp("R1", "reset irq", hardIrqReq, 0);
    cmp("R1", "reset halt", haltCore, 0);
    cmp("R1", "reset rst", coreResetReq, 0);
    rstN = 1'b1;
    step(1);
    cmp("R1", "after reset pend", pendingVec, 0);

    // external interrupt with latency check
    extIrqPin = 1'b1;
    step(2);
    cmp("R2", "ext early", pendingVec[0], 0);
    step(1);
    cmp("R3", "ext high", pendingVec[0], 1);
    cmp("R11", "irq ext", hardIrqReq, 1);
    ack(2'd0);
    cmp("R7", "ack ext active", pendingVec[0], 1);
    extIrqPin = 1'b0;
    step(3);
    cmp("R3", "ext low", pendingVec[0], 0);
    cmp("R11", "irq none", hardIrqReq, 0);

    // system management interrupt
    smiPin = 1'b1; step(3);
    cmp("R4", "smi high", pendingVec[1], 1);
    ack(2'd1);
    cmp("R7", "ack smi active", pendingVec[1], 1);
    smiPin = 1'b0; step(3);
    cmp("R4", "smi low", pendingVec[1], 0);

    // machine check falling edge, rising edge, ack
    mcheckPinN = 1'b0; step(3);
    cmp("R5", "mchk fall", pendingVec[2], 1);
    mcheckPinN = 1'b1; step(3);
    cmp("R5", "mchk rise keeps", pendingVec[2], 1);
    ack(2'd2);
    cmp("R6", "mchk ack", pendingVec[2], 0);
    cmp("R11", "irq after ack", hardIrqReq, 0);

    // held low after ack: no re-trigger
    mcheckPinN = 1'b0; step(3);
    cmp("R5", "mchk fall2", pendingVec[2], 1);
    ack(2'd2);
    step(6);
    cmp("R12", "mchk held low", pendingVec[2], 0);
    mcheckPinN = 1'b1; step(4);

    // coincident new edge and acknowledge
    mcheckPinN = 1'b0;
    step(2);
    ack(2'd2);
    cmp("R6", "set beats ack", pendingVec[2], 1);
    ack(2'd2);
    cmp("R6", "second ack", pendingVec[2], 0);
    mcheckPinN = 1'b1; step(4);

    // checkstop and hard reset
    ckstopPinN = 1'b0; step(3);
    cmp("R8", "halt on", haltCore, 1);
    ckstopPinN = 1'b1; step(3);
    cmp("R8", "halt off", haltCore, 0);
    hresetPinN = 1'b0; step(2);
    cmp("R2", "hreset early", coreResetReq, 0);
    step(1);
    cmp("R9", "hreset on", coreResetReq, 1);
    hresetPinN = 1'b1; step(3);
    cmp("R9", "hreset off", coreResetReq, 0);

    // soft reset
    sresetPin = 1'b1; step(3);
    cmp("R10", "sreset high", pendingVec[3], 1);
    ack(2'd3);
    cmp("R7", "ack sreset active", pendingVec[3], 1);
    sresetPin = 1'b0; step(3);
    cmp("R10", "sreset low", pendingVec[3], 0);

    // overlapping sources
    extIrqPin = 1'b1; smiPin = 1'b1; step(3);
    smiPin = 1'b0; step(3);
    cmp("R11", "irq one left", hardIrqReq, 1);
    extIrqPin = 1'b0; step(3);
    cmp("R11", "irq all clear", hardIrqReq, 0);

    // one-cycle pulses
    extIrqPin = 1'b1; step(1); extIrqPin = 1'b0;
    step(2);
    cmp("R3", "pulse seen", pendingVec[0], 1);
    step(1);
    cmp("R3", "pulse gone", pendingVec[0], 0);
    step(5);
    finishRun();
  end
endmodule